// File: doc/BRIEF.md
# Reversible Range-Bounded Counter

This block is a 7-bit counter that steps up or down by one on each enabled clock edge and wraps between two limits supplied at run time. A lower limit and an upper limit, both 7-bit inputs, define the cycle. Going up, the count climbs to the upper limit and then reloads the lower limit. Going down, it falls to the lower limit and then reloads the upper limit. With limits 40 and 50 counting down, the output runs 50, 49, ... 41, 40, 50, which is an 11-state cycle.

Internally the register is built from 4-bit loadable slices joined by a ripple enable chain. A comparator stage turns the current count, the limits and the direction into one action per edge: hold, step, load the lower limit or load the upper limit. A multiplexer then picks the value that is loaded. A terminal-count flag marks the state from which the next enabled edge wraps.

Limits may change at any time. A count that lies outside the window is pulled back onto the bound from which the chosen direction starts. An inverted window, where the lower limit exceeds the upper limit, freezes the count.

Top module: `rbc_counter`

## Requirements
- R1: While `clr` is high at a rising edge, `count` becomes 0 on that edge. This overrides every other input. The clear is synchronous and active-high.
- R2: With `clr` low and `ce` low, `count` keeps its value across the edge.
- R3: With `ce` high, `up_dn` = 0 (down) and `lo_lim` < `count` <= `hi_lim`, the next edge decrements `count` by one.
- R4: With `ce` high, `up_dn` = 0, `lo_lim` <= `hi_lim` and `count` = `lo_lim`, the next edge loads `hi_lim`. With limits 40 and 50 this gives an 11-state down cycle.
- R5: With `ce` high, `up_dn` = 1 (up) and `lo_lim` <= `count` < `hi_lim`, the next edge increments `count` by one. This holds across the 4-bit slice boundary and for the full 0 to 127 range.
- R6: With `ce` high, `up_dn` = 1, `lo_lim` <= `hi_lim` and `count` = `hi_lim`, the next edge loads `lo_lim`.
- R7: With `ce` high, `lo_lim` <= `hi_lim` and `count` outside [`lo_lim`, `hi_lim`], the next edge loads `hi_lim` when `up_dn` = 0 and `lo_lim` when `up_dn` = 1. After any enabled edge with a valid window, `count` lies inside the window that was present before the edge.
- R8: With `ce` high and `lo_lim` > `hi_lim`, `count` keeps its value.
- R9: `tc` is combinational. It is 1 exactly when `ce` = 1, `lo_lim` <= `hi_lim`, and `count` equals `hi_lim` (up) or `lo_lim` (down). Otherwise it is 0.
- R10: When `lo_lim` = `hi_lim`, the enabled counter settles on that value and stays there with `tc` high, in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous active-high clear to zero |
| ce | input | 1 | Count enable |
| up_dn | input | 1 | Direction select: 1 counts up, 0 counts down |
| lo_lim | input | 7 | Lower bound of the count window |
| hi_lim | input | 7 | Upper bound of the count window |
| count | output | 7 | Current count value |
| tc | output | 1 | Terminal count: the next enabled edge wraps |

## Verification
The window 40 to 50 is run in both directions, starting from a count outside the window. This separates the out-of-range reload from the ordinary wrap at each bound and confirms the 11-state cycle. The full window 0 to 127 carries the count through the slice boundary in both directions and wraps at the extremes. Inverted and single-value windows show that the counter freezes or settles without stepping. A long stretch with pseudo-random limits, gaps in the enable, direction changes and occasional clears compares the count and `tc` on every cycle against a behavioural model. This exposes ordering mistakes between the hold, reload and step decisions.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    // Action chosen for one clock edge
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_STEP    = 2'd1,
        ACT_LOAD_LO = 2'd2,
        ACT_LOAD_HI = 2'd3
    } act_e;

    // Number of slices needed to cover a width
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/rbc_slice.sv
module rbc_slice #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         step_en,
    input  logic         up,
    output logic [W-1:0] q,
    output logic         carry
);

    always_ff @(posedge clk) begin
        if (clr)
            q <= '0;
        else if (load)
            q <= ld_val;
        else if (step_en)
            q <= up ? q + W'(1) : q - W'(1);
    end

    // Ripple enable to the next slice: this slice wraps on this edge
    assign carry = step_en && (up ? (&q) : (~|q));

    // R7
    slice_excl_chk: assert property (@(posedge clk) disable iff (clr)
        !(load && step_en));

endmodule

// File: rtl/rbc_bound_cmp.sv
module rbc_bound_cmp
    import rbc_pkg::*;
#(
    parameter int W = 7
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         ce,
    input  logic         up,
    output act_e         act,
    output logic         tc
);

    logic inverted, outside, at_lo, at_hi;

    assign inverted = lo > hi;
    assign outside  = (count < lo) || (count > hi);
    assign at_lo    = count == lo;
    assign at_hi    = count == hi;

    always_comb begin
        act = ACT_HOLD;
        if (ce && !inverted) begin
            if (outside)
                act = up ? ACT_LOAD_LO : ACT_LOAD_HI;
            else if (up)
                act = at_hi ? ACT_LOAD_LO : ACT_STEP;
            else
                act = at_lo ? ACT_LOAD_HI : ACT_STEP;
        end
    end

    assign tc = ce && !inverted && (up ? at_hi : at_lo);

endmodule

// File: rtl/rbc_load_mux.sv
module rbc_load_mux
    import rbc_pkg::*;
#(
    parameter int W = 7
) (
    input  act_e         act,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         load,
    output logic [W-1:0] ld_val
);

    always_comb begin
        load   = 1'b0;
        ld_val = hi;
        unique case (act)
            ACT_LOAD_LO: begin load = 1'b1; ld_val = lo; end
            ACT_LOAD_HI: begin load = 1'b1; ld_val = hi; end
            default:     begin load = 1'b0; ld_val = hi; end
        endcase
    end

endmodule

// File: rtl/rbc_counter.sv
module rbc_counter
    import rbc_pkg::*;
#(
    parameter int CNT_W   = 7,
    parameter int SLICE_W = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             ce,
    input  logic             up_dn,
    input  logic [CNT_W-1:0] lo_lim,
    input  logic [CNT_W-1:0] hi_lim,
    output logic [CNT_W-1:0] count,
    output logic             tc
);

    localparam int N_SLICES = ceil_div(CNT_W, SLICE_W);
    localparam int REG_W    = N_SLICES * SLICE_W;

    act_e               act;
    logic               do_load;
    logic [CNT_W-1:0]   ld_val;
    logic [REG_W-1:0]   ld_wide;
    logic [REG_W-1:0]   reg_q;
    logic [N_SLICES:0]  chain;

    rbc_bound_cmp #(.W(CNT_W)) u_cmp (
        .count (count),
        .lo    (lo_lim),
        .hi    (hi_lim),
        .ce    (ce),
        .up    (up_dn),
        .act   (act),
        .tc    (tc)
    );

    rbc_load_mux #(.W(CNT_W)) u_mux (
        .act    (act),
        .lo     (lo_lim),
        .hi     (hi_lim),
        .load   (do_load),
        .ld_val (ld_val)
    );

    always_comb begin
        ld_wide             = '0;
        ld_wide[CNT_W-1:0]  = ld_val;
    end

    assign chain[0] = (act == ACT_STEP);

    for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
        rbc_slice #(.W(SLICE_W)) u_slice (
            .clk     (clk),
            .clr     (clr),
            .load    (do_load),
            .ld_val  (ld_wide[i*SLICE_W +: SLICE_W]),
            .step_en (chain[i]),
            .up      (up_dn),
            .q       (reg_q[i*SLICE_W +: SLICE_W]),
            .carry   (chain[i+1])
        );
    end

    assign count = reg_q[CNT_W-1:0];

    // R5
    no_top_carry_chk: assert property (@(posedge clk) disable iff (clr)
        !chain[N_SLICES]);

    if (REG_W > CNT_W) begin : g_pad_chk
        // R5
        pad_bits_zero_chk: assert property (@(posedge clk) disable iff (clr)
            reg_q[REG_W-1:CNT_W] == '0);
    end

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (clr)
        !ce |=> $stable(count));

    // R8
    hold_inverted_chk: assert property (@(posedge clk) disable iff (clr)
        (ce && lo_lim > hi_lim) |=> $stable(count));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (clr)
        (ce && !up_dn && count > lo_lim && count <= hi_lim)
        |=> count == $past(count) - CNT_W'(1));

    // R5
    step_up_chk: assert property (@(posedge clk) disable iff (clr)
        (ce && up_dn && count >= lo_lim && count < hi_lim)
        |=> count == $past(count) + CNT_W'(1));

    // R4
    wrap_down_chk: assert property (@(posedge clk) disable iff (clr)
        (ce && !up_dn && lo_lim <= hi_lim && count == lo_lim)
        |=> count == $past(hi_lim));

    // R6
    wrap_up_chk: assert property (@(posedge clk) disable iff (clr)
        (ce && up_dn && lo_lim <= hi_lim && count == hi_lim)
        |=> count == $past(lo_lim));

    // R7
    land_in_window_chk: assert property (@(posedge clk) disable iff (clr)
        (ce && lo_lim <= hi_lim)
        |=> (count >= $past(lo_lim) && count <= $past(hi_lim)));

    // R9
    tc_gate_chk: assert property (@(posedge clk) disable iff (clr)
        tc |-> (ce && (count == lo_lim || count == hi_lim)));

endmodule

// File: tb/tb_rbc_counter.sv
`timescale 1ns/1ps
module tb_rbc_counter;

    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       ce = 1'b0;
    logic       up_dn = 1'b0;
    logic [6:0] lo_lim = '0;
    logic [6:0] hi_lim = '0;
    logic [6:0] count;
    logic       tc;

    int  checks = 0;
    int  errors = 0;
    int  model  = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    rbc_counter dut (
        .clk    (clk),
        .clr    (clr),
        .ce     (ce),
        .up_dn  (up_dn),
        .lo_lim (lo_lim),
        .hi_lim (hi_lim),
        .count  (count),
        .tc     (tc)
    );

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle: drive after the falling edge, check tc, then the count after the edge
    task automatic cycle(input bit c_clr, input bit c_ce, input bit c_up,
                         input int c_lo, input int c_hi);
        int    nxt;
        int    exp_tc;
        string tag;
        clr    = c_clr;
        ce     = c_ce;
        up_dn  = c_up;
        lo_lim = 7'(c_lo);
        hi_lim = 7'(c_hi);
        #1;
        exp_tc = (c_ce && c_lo <= c_hi && (c_up ? model == c_hi : model == c_lo)) ? 1 : 0;
        check_val((c_lo == c_hi) ? "R10 tc" : "R9 tc", int'(tc), exp_tc);
        if (c_clr) begin
            nxt = 0;  tag = "R1 clear";
        end else if (!c_ce) begin
            nxt = model; tag = "R2 idle hold";
        end else if (c_lo > c_hi) begin
            nxt = model; tag = "R8 inverted hold";
        end else if (model < c_lo || model > c_hi) begin
            nxt = c_up ? c_lo : c_hi; tag = "R7 out of window";
        end else if (c_lo == c_hi) begin
            nxt = c_lo; tag = "R10 single value";
        end else if (c_up) begin
            if (model == c_hi) begin nxt = c_lo; tag = "R6 up wrap"; end
            else begin nxt = model + 1; tag = "R5 up step"; end
        end else begin
            if (model == c_lo) begin nxt = c_hi; tag = "R4 down wrap"; end
            else begin nxt = model - 1; tag = "R3 down step"; end
        end
        @(posedge clk);
        @(negedge clk);
        model = nxt;
        check_val(tag, int'(count), model);
    endtask

    initial begin
        @(negedge clk);
        // reset state: R1
        check_val("R1 reset count", int'(count), 0);
        check_val("R9 reset tc", int'(tc), 0);
        model = 0;
        cycle(1, 0, 0, 0, 0);

        // 40..50 down from outside the window (R7 then R3/R4)
        for (int i = 0; i < 30; i++) cycle(0, 1, 0, 40, 50);
        // same window upward (R5/R6)
        for (int i = 0; i < 25; i++) cycle(0, 1, 1, 40, 50);
        // enable low (R2)
        for (int i = 0; i < 5; i++) cycle(0, 0, 1, 40, 50);
        // window moves above the count while counting up (R7)
        for (int i = 0; i < 4; i++) cycle(0, 1, 1, 60, 70);
        for (int i = 0; i < 4; i++) cycle(0, 1, 0, 60, 70);
        // inverted window (R8)
        for (int i = 0; i < 5; i++) cycle(0, 1, 0, 80, 20);
        for (int i = 0; i < 3; i++) cycle(0, 1, 1, 80, 20);
        // single-value window (R10)
        for (int i = 0; i < 4; i++) cycle(0, 1, 1, 33, 33);
        for (int i = 0; i < 4; i++) cycle(0, 1, 0, 33, 33);
        // full range through slice boundary and both extremes (R5, R6, R3, R4)
        cycle(1, 1, 1, 0, 127);
        for (int i = 0; i < 131; i++) cycle(0, 1, 1, 0, 127);
        for (int i = 0; i < 20; i++) cycle(0, 1, 0, 0, 127);
        // clear while enabled (R1)
        cycle(1, 1, 0, 0, 127);
        for (int i = 0; i < 20; i++) cycle(0, 1, 0, 0, 127);

        // pseudo-random mix
        begin
            int lo = 10, hi = 90, up = 1;
            for (int i = 0; i < 400; i++) begin
                if (i % 40 == 0) begin
                    lo = int'($urandom % 128);
                    hi = (i % 120 == 80) ? int'($urandom % 128) : lo + int'($urandom % (128 - lo));
                end
                if (i % 23 == 0) up = int'($urandom % 2);
                cycle(($urandom % 97) == 0, ($urandom % 4) != 0, up[0], lo, hi);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule